// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the outcomes of the most recent branches, which is the global history. It also keeps a two-dimensional array of small saturating counters. The low-order bits of the branch address pick a row of the array. The current global history picks a column inside that row. The counter at that crossing supplies the prediction in the same cycle as the lookup.

When a branch resolves, the caller presents its address, its real outcome and the history value that was current when that branch was predicted. The counter at that address and history is trained toward the outcome. The outcome is then shifted into the global history. No address tag is kept, so two branches whose low address bits match share their counters.

The index width, the history width and the counter width are all parameters. The default is a 4-bit index, a 2-bit history and 2-bit counters, which gives 64 counters.

Top module: `gcorr_predictor`

## Requirements
- R1: After reset, every counter holds the weakly-not-taken value 2^(n-1)-1 and the global history is zero, so every lookup predicts not taken.
- R2: The lookup prediction is 1 (taken) exactly when the selected counter is at least 2^(n-1). The selected counter is the one at row `lk_pc` and column `ghist_o`, and the flat index is {row, column}.
- R3: An update with `up_taken`=1 raises the counter at row `up_pc`, column `up_hist` by one. A counter already at 2^n-1 stays there.
- R4: An update with `up_taken`=0 lowers that counter by one. A counter already at 0 stays there.
- R5: Each update shifts `up_taken` into bit 0 of the history (1 means taken) and drops the oldest bit. While `up_valid` is low, the history does not change.
- R6: The column that an update trains comes from `up_hist`, not from the current history.
- R7: An update changes only the addressed counter. While `up_valid` is low, no counter changes, whatever the other update inputs carry.
- R8: The lookup is combinational. A lookup made in the same cycle as an update of the same counter sees the value from before the update, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | IDX_W | Low address bits of the branch being predicted |
| lk_taken | output | 1 | Prediction: 1 for taken, 0 for not taken |
| ghist_o | output | HIST_W | Current global history; the caller saves it alongside each prediction |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | IDX_W | Low address bits of the resolved branch |
| up_hist | input | HIST_W | History value that was saved when that branch was predicted |
| up_taken | input | 1 | Resolved outcome: 1 for taken |

## Verification
A counter can only be observed when the live history equals its column. Every update moves the history, so reading a trained counter back is the difficult step. Saturation needs a run of updates to one entry and then a read-back in that same column. The bench gets there by training the entry with an explicit `up_hist` and then steering the history back to that column: it issues throw-away updates on a scratch row, with their outcomes chosen bit by bit. The same steering exposes the training column for R6, and it shows that a neighbouring row was left alone for R7.

// File: rtl/gcorr_pkg.sv
package gcorr_pkg;

    // direction applied to a saturating counter on training
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } ctr_dir_e;

    localparam int unsigned DEF_IDX_W  = 4;
    localparam int unsigned DEF_HIST_W = 2;
    localparam int unsigned DEF_CTR_W  = 2;

endpackage

// File: rtl/gcorr_sat_step.sv
module gcorr_sat_step
    import gcorr_pkg::*;
#(
    parameter int unsigned CTR_W = DEF_CTR_W
) (
    input  logic [CTR_W-1:0] cur_i,
    input  ctr_dir_e         dir_i,
    output logic [CTR_W-1:0] nxt_o
);
    localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CMIN = '0;

    always_comb begin
        nxt_o = cur_i;
        if (dir_i == DIR_UP) begin
            if (cur_i != CMAX) nxt_o = cur_i + 1'b1;
        end else begin
            if (cur_i != CMIN) nxt_o = cur_i - 1'b1;
        end
    end
endmodule

// File: rtl/gcorr_hist.sv
module gcorr_hist
    import gcorr_pkg::*;
#(
    parameter int unsigned HIST_W = DEF_HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_st_t;

    hist_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_en) begin
            // newest outcome enters at bit 0, oldest falls off the top
            s_d.hist = HIST_W'({s_q.hist, bit_in});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hist_o = s_q.hist;
endmodule

// File: rtl/gcorr_ctr_table.sv
module gcorr_ctr_table
    import gcorr_pkg::*;
#(
    parameter int unsigned IDX_W  = DEF_IDX_W,
    parameter int unsigned HIST_W = DEF_HIST_W,
    parameter int unsigned CTR_W  = DEF_CTR_W
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_en,
    input  logic [IDX_W+HIST_W-1:0]                      wr_idx,
    input  logic [CTR_W-1:0]                             wr_val,
    output logic [(1<<(IDX_W+HIST_W))-1:0][CTR_W-1:0]    ctr_o
);
    localparam int unsigned TBL_W   = IDX_W + HIST_W;
    localparam int unsigned ENTRIES = 1 << TBL_W;
    localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W-1)) - 1);

    typedef struct packed {
        logic [ENTRIES-1:0][CTR_W-1:0] ctr;
    } tbl_st_t;

    tbl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.ctr[wr_idx] = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.ctr <= {ENTRIES{WEAK_NT}};
        else        s_q     <= s_d;
    end

    assign ctr_o = s_q.ctr;
endmodule

// File: rtl/gcorr_predictor.sv
module gcorr_predictor
    import gcorr_pkg::*;
#(
    parameter int unsigned IDX_W  = DEF_IDX_W,
    parameter int unsigned HIST_W = DEF_HIST_W,
    parameter int unsigned CTR_W  = DEF_CTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] ghist_o,
    input  logic              up_valid,
    input  logic [IDX_W-1:0]  up_pc,
    input  logic [HIST_W-1:0] up_hist,
    input  logic              up_taken
);
    localparam int unsigned TBL_W   = IDX_W + HIST_W;
    localparam int unsigned ENTRIES = 1 << TBL_W;

    logic [ENTRIES-1:0][CTR_W-1:0] ctr_all;
    logic [TBL_W-1:0]              lk_idx;
    logic [TBL_W-1:0]              up_idx;
    logic [CTR_W-1:0]              lk_ctr;
    logic [CTR_W-1:0]              up_cur;
    logic [CTR_W-1:0]              up_nxt;
    ctr_dir_e                      up_dir;

    // row from address bits, column from history
    assign lk_idx = {lk_pc, ghist_o};
    assign up_idx = {up_pc, up_hist};

    assign lk_ctr   = ctr_all[lk_idx];
    assign lk_taken = lk_ctr[CTR_W-1];

    assign up_cur = ctr_all[up_idx];
    assign up_dir = up_taken ? DIR_UP : DIR_DOWN;

    gcorr_sat_step #(.CTR_W(CTR_W)) u_step (
        .cur_i (up_cur),
        .dir_i (up_dir),
        .nxt_o (up_nxt)
    );

    gcorr_ctr_table #(
        .IDX_W  (IDX_W),
        .HIST_W (HIST_W),
        .CTR_W  (CTR_W)
    ) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (up_valid),
        .wr_idx (up_idx),
        .wr_val (up_nxt),
        .ctr_o  (ctr_all)
    );

    gcorr_hist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist_o   (ghist_o)
    );
endmodule

// File: rtl/gcorr_predictor_chk.sv
module gcorr_predictor_chk #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned HIST_W = 2,
    parameter int unsigned CTR_W  = 2
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic                                       up_valid,
    input logic                                       up_taken,
    input logic [HIST_W-1:0]                          ghist_o,
    input logic [IDX_W+HIST_W-1:0]                    up_idx,
    input logic [CTR_W-1:0]                           up_cur,
    input logic [(1<<(IDX_W+HIST_W))-1:0][CTR_W-1:0]  ctr_all
);
    localparam int unsigned TBL_W = IDX_W + HIST_W;
    localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

    logic [TBL_W-1:0] idx_p;
    logic [CTR_W-1:0] ctr_at_p;

    always_ff @(posedge clk) begin
        if (!rst_n) idx_p <= '0;
        else        idx_p <= up_idx;
    end

    assign ctr_at_p = ctr_all[idx_p];

    // R3
    ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_taken && up_cur != CMAX |=> ctr_at_p == CTR_W'($past(up_cur) + 1'b1));

    // R3
    ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_taken && up_cur == CMAX |=> ctr_at_p == CMAX);

    // R4
    ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_taken && up_cur != '0 |=> ctr_at_p == CTR_W'($past(up_cur) - 1'b1));

    // R4
    ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_taken && up_cur == '0 |=> ctr_at_p == '0);

    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> ghist_o == HIST_W'({$past(ghist_o), $past(up_taken)}));

    // R5
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ghist_o));

    // R7
    tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ctr_all));
endmodule

bind gcorr_predictor gcorr_predictor_chk #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W),
    .CTR_W  (CTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .ghist_o  (ghist_o),
    .up_idx   (up_idx),
    .up_cur   (up_cur),
    .ctr_all  (ctr_all)
);

// File: tb/tb_gcorr_predictor.sv
`timescale 1ns/100ps
module tb_gcorr_predictor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] lk_pc = '0;
    logic       lk_taken;
    logic [1:0] ghist_o;
    logic       up_valid = 1'b0;
    logic [3:0] up_pc = '0;
    logic [1:0] up_hist = '0;
    logic       up_taken = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // independent model of the counter array (row*4 + column) and history
    int         mdl [64];
    logic [1:0] mgh;

    always #2 clk = ~clk;

    gcorr_predictor dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .ghist_o(ghist_o), .up_valid(up_valid), .up_pc(up_pc),
        .up_hist(up_hist), .up_taken(up_taken)
    );

    typedef struct packed {
        logic [3:0] pc;
        logic [1:0] gh;
        logic       tk;
        logic [1:0] exp_gh;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{4'd3,  2'd0, 1'b1, 2'd1},
        '{4'd3,  2'd1, 1'b1, 2'd3},
        '{4'd5,  2'd3, 1'b0, 2'd2},
        '{4'd5,  2'd2, 1'b1, 2'd1},
        '{4'd3,  2'd1, 1'b1, 2'd3},
        '{4'd9,  2'd3, 1'b0, 2'd2},
        '{4'd9,  2'd2, 1'b0, 2'd0},
        '{4'd15, 2'd0, 1'b1, 2'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_update(input logic [3:0] pc, input logic [1:0] gh, input logic tk);
        int idx;
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_hist = gh; up_taken = tk;
        @(posedge clk);
        #1;
        up_valid = 1'b0;
        idx = pc * 4 + gh;
        if (tk) mdl[idx] = (mdl[idx] == 3) ? 3 : mdl[idx] + 1;
        else    mdl[idx] = (mdl[idx] == 0) ? 0 : mdl[idx] - 1;
        mgh = {mgh[0], tk};
    endtask

    // R2: prediction from the counter at {lk_pc, history}
    task automatic look(input logic [3:0] pc, input string req);
        lk_pc = pc;
        #0.5;
        chk(req, lk_taken, (mdl[pc * 4 + mgh] >= 2) ? 1 : 0);
    endtask

    // drive the history to a chosen column through a scratch row
    task automatic steer(input logic [1:0] t);
        do_update(4'd0, 2'd0, t[1]);
        do_update(4'd0, 2'd0, t[0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        foreach (mdl[i]) mdl[i] = 1;
        mgh = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;

        // R1: reset state
        chk("R1 history", ghist_o, 0);
        for (int p = 0; p < 16; p++) begin
            lk_pc = p[3:0];
            #0.5;
            chk("R1 weak-not-taken", lk_taken, 0);
        end

        // vector walk: R5 shift, R2 prediction
        for (int v = 0; v < 8; v++) begin
            do_update(VEC[v].pc, VEC[v].gh, VEC[v].tk);
            chk("R5 shift", ghist_o, VEC[v].exp_gh);
            look(VEC[v].pc, "R2 vector lookup");
        end

        // R3: raise pc7/col3 past saturation
        steer(2'd3);
        for (int i = 0; i < 4; i++) do_update(4'd7, 2'd3, 1'b1);
        steer(2'd3);
        look(4'd7, "R3 saturated taken");
        chk("R3 model top", mdl[7*4+3], 3);
        do_update(4'd7, 2'd3, 1'b0);
        steer(2'd3);
        look(4'd7, "R3 no wrap at top");
        do_update(4'd7, 2'd3, 1'b0);
        steer(2'd3);
        look(4'd7, "R3 two steps down");

        // R4: drive to zero and beyond
        for (int i = 0; i < 4; i++) do_update(4'd7, 2'd3, 1'b0);
        do_update(4'd7, 2'd3, 1'b1);
        steer(2'd3);
        look(4'd7, "R4 no wrap at bottom");
        do_update(4'd7, 2'd3, 1'b1);
        steer(2'd3);
        look(4'd7, "R4 recovered to taken");

        // R7: neighbouring row untouched
        look(4'd8, "R7 neighbour row");
        steer(2'd0);
        look(4'd7, "R7 other column of trained row");

        // R6: training column from up_hist, not live history
        do_update(4'd10, 2'd2, 1'b1);
        do_update(4'd10, 2'd2, 1'b1);
        steer(2'd2);
        look(4'd10, "R6 supplied column trained");
        steer(2'd0);
        look(4'd10, "R6 live column untouched");

        // R5/R7: inputs toggle with up_valid low
        @(negedge clk);
        up_pc = 4'd10; up_hist = 2'd0; up_taken = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R5 hold without strobe", ghist_o, mgh);
        look(4'd10, "R7 no write without strobe");

        // R8: same-cycle lookup sees old value, next cycle sees new
        steer(2'd0);
        @(negedge clk);
        up_valid = 1'b1; up_pc = 4'd6; up_hist = 2'd0; up_taken = 1'b1;
        lk_pc = 4'd6;
        #0.5;
        chk("R8 old value during update", lk_taken, 0);
        @(posedge clk);
        #1;
        up_valid = 1'b0;
        mdl[6*4+0] = 2;
        mgh = {mgh[0], 1'b1};
        steer(2'd0);
        look(4'd6, "R8 new value after edge");
        chk("R8 model", mdl[6*4+0], 2);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule